// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps the time of day as six BCD digits (hours, minutes, seconds) from a timebase that delivers 60 one-cycle pulses per second. A divider inside the block turns every sixtieth timebase pulse into a once-per-second tick. Seconds and minutes are each built as a decade digit feeding a modulo-6 digit. Hours are a twelve-state counter whose value is always shown in the range 1 to 12, so the time advances from 12:59:59 to 01:00:00.

All counting is synchronous to the one system clock. Each stage passes a one-cycle enable to the next, and the same enables are brought out as carry pulses so that a neighbour block can follow the count. Two set strobes let an operator step the minutes or the hours by one without moving anything above them. The inputs are plain control pins: a pulse is taken in the cycle it is high, and there is no handshake and no back-pressure.

Top module: `hms12_clock`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the digits read 12:00:00 (hours tens 1, hours units 2, all other digits 0), every carry output is low and the pulse divider holds zero counted pulses.
- R2: `tick_o` is high in exactly the cycle that carries the 60th, 120th, ... high cycle of `pulse60_i` counted since reset; it is never high without `pulse60_i`, and idle cycles between pulses do not count.
- R3: On each edge where `tick_o` is high, the seconds units digit steps 0..9 and back to 0; `sec_ones_carry_o` is high in the cycle where `tick_o` is high and that digit is 9.
- R4: The seconds tens digit steps 0..5 each time the units digit wraps; `sec_carry_o` is high in the cycle where `tick_o` is high and the seconds read 59, so seconds never leave 00..59.
- R5: The minutes digits count 00..59 on `sec_carry_o`; `min_ones_carry_o` is high when `sec_carry_o` is high and the minutes units digit is 9, and `min_carry_o` is high when `sec_carry_o` is high and the minutes read 59 (once per hour).
- R6: Hours advance on `min_carry_o` through 1..12 and are never 0 or above 12; from 12:59:59 the next tick gives 01:00:00.
- R7: `half_day_o` is high in the cycle where `min_carry_o` is high and the hours read 11, so it marks the step from 11:59:59 to 12:00:00 and not the step from 12 to 1.
- R8: A high `set_min_i` advances the minutes by one (59 goes to 00) on that edge, leaves seconds and hours unchanged, and raises neither `min_carry_o` nor `min_ones_carry_o` on its own.
- R9: A high `set_hour_i` advances the hours by one (12 goes to 1) on that edge, leaves minutes and seconds unchanged, and does not raise `half_day_o` on its own.
- R10: When a set strobe coincides with a carry into the same stage, the stage advances only once, and the carry out of that stage follows the carry alone; digits change only on edges where `tick_o` or a set strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse60_i | input | 1 | Timebase pulse, 60 per second, one cycle wide |
| set_min_i | input | 1 | Step minutes by one |
| set_hour_i | input | 1 | Step hours by one |
| sec_ones_o | output | 4 | Seconds units, BCD |
| sec_tens_o | output | 4 | Seconds tens, BCD 0..5 |
| min_ones_o | output | 4 | Minutes units, BCD |
| min_tens_o | output | 4 | Minutes tens, BCD 0..5 |
| hr_ones_o | output | 4 | Hours units, BCD |
| hr_tens_o | output | 4 | Hours tens, BCD 0..1 |
| tick_o | output | 1 | Once-per-second tick |
| sec_ones_carry_o | output | 1 | Seconds units wrap pulse |
| sec_carry_o | output | 1 | Once-per-minute pulse |
| min_ones_carry_o | output | 1 | Minutes units wrap pulse |
| min_carry_o | output | 1 | Once-per-hour pulse |
| half_day_o | output | 1 | Pulse on the step into 12 o'clock |

## Verification
The hard states are the hour boundaries: reaching 12:59:59 or 11:59:59 by counting alone would take millions of cycles. The stimulus uses the set strobes to jump the hours and minutes into place, then feeds back-to-back timebase pulses to run the seconds through the last minute, so both the 12-to-1 wrap and the half-day pulse occur in a few thousand cycles. A set-minute strobe is also placed exactly on the tick that wraps the seconds, to reach the coincident-advance case.

// File: rtl/hms12_pkg.sv
package hms12_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;

  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } bcd_pair_t;

  function automatic bcd_pair_t to_pair(input int unsigned v);
    bcd_pair_t r;
    r.tens = DIGIT_W'((v / 10) % 10);
    r.ones = DIGIT_W'(v % 10);
    return r;
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] seen_q;

  assign tick_o = pulse_i && (seen_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (pulse_i) begin
      if (tick_o) seen_q <= '0;
      else        seen_q <= seen_q + 1'b1;
    end
  end
endmodule

// File: rtl/mod_digit.sv
module mod_digit
  import hms12_pkg::*;
#(
  parameter int MODULUS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output bcd_t value_o,
  output logic wrap_o
);
  localparam bcd_t TOP = DIGIT_W'(MODULUS - 1);

  bcd_t val_q;

  assign value_o = val_q;
  assign wrap_o  = en_i && (val_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (en_i) begin
      if (val_q == TOP) val_q <= '0;
      else              val_q <= val_q + 1'b1;
    end
  end
endmodule

// File: rtl/sexa_stage.sv
module sexa_stage
  import hms12_pkg::*;
#(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output bcd_t ones_o,
  output bcd_t tens_o,
  output logic ones_wrap_o,
  output logic wrap_o
);
  localparam int NDIG = 2;
  localparam int MODS [NDIG] = '{UNITS_MOD, TENS_MOD};

  logic [NDIG:0] chain;
  bcd_t          dig [NDIG];

  assign chain[0] = en_i;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    mod_digit #(.MODULUS(MODS[i])) u_digit (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (chain[i]),
      .value_o(dig[i]),
      .wrap_o (chain[i+1])
    );
  end

  assign ones_o      = dig[0];
  assign tens_o      = dig[1];
  assign ones_wrap_o = chain[1];
  assign wrap_o      = chain[NDIG];
endmodule

// File: rtl/hour_stage.sv
module hour_stage
  import hms12_pkg::*;
#(
  parameter int HOURS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ripple_i,
  output bcd_t ones_o,
  output bcd_t tens_o,
  output logic half_o
);
  localparam int HW = $clog2(HOURS + 1);
  localparam logic [HW-1:0] TOP = HW'(HOURS);
  localparam logic [HW-1:0] PRE = HW'(HOURS - 1);

  logic [HW-1:0] hr_q;
  bcd_pair_t     shown;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_q <= TOP;
    end else if (en_i) begin
      if (hr_q == TOP) hr_q <= HW'(1);
      else             hr_q <= hr_q + 1'b1;
    end
  end

  assign half_o = ripple_i && (hr_q == PRE);

  always_comb shown = to_pair(32'(hr_q));

  assign ones_o = shown.ones;
  assign tens_o = shown.tens;
endmodule

// File: rtl/hms12_clock.sv
module hms12_clock
  import hms12_pkg::*;
#(
  parameter int PRESCALE = 60,
  parameter int HOURS    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse60_i,
  input  logic       set_min_i,
  input  logic       set_hour_i,
  output logic [3:0] sec_ones_o,
  output logic [3:0] sec_tens_o,
  output logic [3:0] min_ones_o,
  output logic [3:0] min_tens_o,
  output logic [3:0] hr_ones_o,
  output logic [3:0] hr_tens_o,
  output logic       tick_o,
  output logic       sec_ones_carry_o,
  output logic       sec_carry_o,
  output logic       min_ones_carry_o,
  output logic       min_carry_o,
  output logic       half_day_o
);
  logic tick;
  logic s_ones_wrap, s_wrap;
  logic m_en, m_ones_raw, m_wrap_raw;
  logic h_en, h_ripple;

  tick_divider #(.DIV(PRESCALE)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .pulse_i(pulse60_i),
    .tick_o (tick)
  );

  sexa_stage #(.UNITS_MOD(10), .TENS_MOD(6)) u_sec (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (tick),
    .ones_o     (sec_ones_o),
    .tens_o     (sec_tens_o),
    .ones_wrap_o(s_ones_wrap),
    .wrap_o     (s_wrap)
  );

  // a set strobe merges into the enable; carries follow the ripple only
  assign m_en = s_wrap | set_min_i;

  sexa_stage #(.UNITS_MOD(10), .TENS_MOD(6)) u_min (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (m_en),
    .ones_o     (min_ones_o),
    .tens_o     (min_tens_o),
    .ones_wrap_o(m_ones_raw),
    .wrap_o     (m_wrap_raw)
  );

  assign h_ripple = m_wrap_raw & s_wrap;
  assign h_en     = h_ripple | set_hour_i;

  hour_stage #(.HOURS(HOURS)) u_hour (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (h_en),
    .ripple_i(h_ripple),
    .ones_o  (hr_ones_o),
    .tens_o  (hr_tens_o),
    .half_o  (half_day_o)
  );

  assign tick_o           = tick;
  assign sec_ones_carry_o = s_ones_wrap;
  assign sec_carry_o      = s_wrap;
  assign min_ones_carry_o = m_ones_raw & s_wrap;
  assign min_carry_o      = h_ripple;
endmodule

// File: rtl/hms12_clock_chk.sv
module hms12_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse60_i,
  input logic       set_min_i,
  input logic       set_hour_i,
  input logic [3:0] sec_ones_o,
  input logic [3:0] sec_tens_o,
  input logic [3:0] min_ones_o,
  input logic [3:0] min_tens_o,
  input logic [3:0] hr_ones_o,
  input logic [3:0] hr_tens_o,
  input logic       tick_o,
  input logic       sec_carry_o,
  input logic       min_carry_o,
  input logic       half_day_o
);
  // R2
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> pulse60_i);

  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_ones_o <= 4'd9) && (sec_tens_o <= 4'd5));

  // R6
  hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hr_tens_o == 4'd0) && (hr_ones_o >= 4'd1) && (hr_ones_o <= 4'd9)) ||
    ((hr_tens_o == 4'd1) && (hr_ones_o <= 4'd2)));

  // R10
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable({sec_tens_o, sec_ones_o}));

  // R8
  set_min_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_min_i && !sec_carry_o) |-> !min_carry_o);

  // R9
  set_hour_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hour_i && !set_min_i && !sec_carry_o) |=> $stable({min_tens_o, min_ones_o}));

  // R6
  wrap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_carry_o && !set_hour_i && hr_tens_o == 4'd1 && hr_ones_o == 4'd2)
    |=> (hr_tens_o == 4'd0 && hr_ones_o == 4'd1));

  // R7
  half_day_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_day_o && !set_hour_i) |=> (hr_tens_o == 4'd1 && hr_ones_o == 4'd2));
endmodule

bind hms12_clock hms12_clock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pulse60_i  (pulse60_i),
  .set_min_i  (set_min_i),
  .set_hour_i (set_hour_i),
  .sec_ones_o (sec_ones_o),
  .sec_tens_o (sec_tens_o),
  .min_ones_o (min_ones_o),
  .min_tens_o (min_tens_o),
  .hr_ones_o  (hr_ones_o),
  .hr_tens_o  (hr_tens_o),
  .tick_o     (tick_o),
  .sec_carry_o(sec_carry_o),
  .min_carry_o(min_carry_o),
  .half_day_o (half_day_o)
);

// File: tb/hms12_clock_bench.sv
module hms12_clock_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic pulse = 1'b0, smin = 1'b0, shour = 1'b0;
  logic [3:0] so, st, mo, mt, ho, ht;
  logic tk, csu, cs, cmu, cm, chd;

  hms12_clock u_hms12_clock (
    .clk(clk), .rst_n(rst_n), .pulse60_i(pulse), .set_min_i(smin), .set_hour_i(shour),
    .sec_ones_o(so), .sec_tens_o(st), .min_ones_o(mo), .min_tens_o(mt),
    .hr_ones_o(ho), .hr_tens_o(ht), .tick_o(tk), .sec_ones_carry_o(csu),
    .sec_carry_o(cs), .min_ones_carry_o(cmu), .min_carry_o(cm), .half_day_o(chd)
  );

  typedef struct {
    logic [29:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;
  int h = 12, m = 0, s = 0, pc = 0;

  function automatic logic [7:0] digs(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected observation
  task automatic step(input bit p, input bit sm, input bit sh, input string req);
    item_t it;
    bit t, c_su, c_s, c_mu, c_m, c_h;
    @(posedge clk);
    #2;
    pulse = p; smin = sm; shour = sh;
    t    = p && (pc == 59);
    c_su = t && (s % 10 == 9);
    c_s  = t && (s == 59);
    c_mu = c_s && (m % 10 == 9);
    c_m  = c_s && (m == 59);
    c_h  = c_m && (h == 11);
    it.exp = {digs(h), digs(m), digs(s), t, c_su, c_s, c_mu, c_m, c_h};
    it.req = req;
    q.push_back(it);
    if (p) pc = t ? 0 : pc + 1;
    if (t) s = (s + 1) % 60;
    if (c_s || sm) m = (m + 1) % 60;
    if (c_m || sh) h = (h == 12) ? 1 : h + 1;
  endtask

  task automatic pulses(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, req);
      for (int g = 0; g < gap; g++) step(0, 0, 0, req);
    end
  endtask

  // monitor: pops and compares in the middle of each cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [29:0] act;
      it  = q.pop_front();
      act = {ht, ho, mt, mo, st, so, tk, csu, cs, cmu, cm, chd};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: got %h expected %h at %0t", it.req, act, it.exp, $time);
      end
    end
  end

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state observed while reset is low
    #2;
    compared++;
    if ({ht, ho, mt, mo, st, so, tk, csu, cs, cmu, cm, chd} !== {8'h12, 16'h0, 6'b0}) begin
      mismatched++;
      $display("FAIL R1: got %h expected %h", {ht, ho, mt, mo, st, so}, 24'h120000);
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R1");
    // R2: sparse pulses, idle cycles must not count
    pulses(120, 2, "R2");
    // R3: dense pulses across the units wrap
    pulses(60 * 8, 0, "R3");
    // R4: on to the minute wrap
    pulses(60 * 50, 0, "R4");
    // R8: step minutes a full lap (59->00 with no hour change), then to 59
    for (int i = 0; i < 60; i++) step(0, 1, 0, "R8");
    for (int i = 0; i < 58; i++) step(0, 1, 0, "R8");
    // R5 / R6: run the last minute, 12:59:59 -> 01:00:00
    pulses(60 * 60, 0, "R6");
    // R9: a full lap of hours, passing 12->1 with no half-day pulse
    for (int i = 0; i < 12; i++) step(0, 0, 1, "R9");
    for (int i = 0; i < 10; i++) step(0, 0, 1, "R9");
    for (int i = 0; i < 59; i++) step(0, 1, 0, "R8");
    // R7: 11:59:59 -> 12:00:00 raises the half-day pulse; R5 hourly carry
    pulses(60 * 60, 0, "R7");
    // R10: set-minute strobe on the tick that wraps seconds
    pulses(60 * 59, 0, "R5");
    for (int i = 0; i < 60; i++) step(1, i == 59, 0, "R10");
    // R10: set-hour strobe together with a set-minute strobe
    step(0, 1, 1, "R10");
    step(0, 0, 0, "R10");
    @(posedge clk);
    #2;
    pulse = 0; smin = 0; shour = 0;
    while (q.size() > 0) @(negedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule